// File: doc/BRIEF.md
# Configurable-Aspect Dual-Port RAM

This block is a simple dual-port memory holding a fixed pool of 1,152 bits. One port only writes and one port only reads, and each runs on its own clock. A two-bit shape select reinterprets the same bit pool as one of four depth-by-width organisations: 64 words of 18 bits, 128 of 9, 256 of 4 or 512 of 2. The address and data pins are always sized for the widest case.

Word `a` of a shape whose width is `w` occupies pool bits `a*w` up to `a*w + w - 1`. Data written under one shape can therefore be read back under another by bit offset. The read port works in one of two ways. In the registered way, the read address is captured on the read clock edge while the read enable is high. In the flow-through way, the read data follows the read address with no clock at all. A level input chooses between the two. An active-low reset clears only the registered read word. The pool itself has no reset.

The shape select is expected to stay still while traffic is running. Both clocks may run at unrelated rates.

Top module: `cfg_aspect_dpram`

## Requirements
- R1: The `shape` input selects the organisation: 2'b00 = 64x18, 2'b01 = 128x9, 2'b10 = 256x4, 2'b11 = 512x2. Word `a` of width `w` maps to pool bits `a*w` through `a*w+w-1`, with data bit 0 at the lowest pool bit. One 1,152-bit pool is shared by all four shapes.
- R2: A write takes place only on a rising `wr_clk` edge where `wr_en` is sampled high. `wr_addr` and `wr_data` are taken from that same edge. With `wr_en` low, the pool is unchanged.
- R3: Address bits at or above log2(depth) of the current shape are ignored on both ports. For example, under 128x9, address 9'h185 selects word 9'h005.
- R4: Under a shape of width `w`, only `wr_data[w-1:0]` is stored, and `rd_data[17:w]` is always zero.
- R5: With `rd_async` low, `rd_addr` and `rd_en` are sampled on a rising `rd_clk` edge. `rd_data` shows the addressed word after that edge.
- R6: With `rd_async` low, an `rd_clk` edge that samples `rd_en` low leaves `rd_data` unchanged. This holds even if `rd_addr` changes or the stored word is rewritten.
- R7: With `rd_async` high, `rd_data` follows `rd_addr` combinationally, with no `rd_clk` edge involved.
- R8: A write to the word being read becomes visible. With `rd_async` high, it appears right after the `wr_clk` edge. With `rd_async` low and `rd_en` high, it appears after the first `rd_clk` edge that follows the write.
- R9: While `rst_n` is low, the registered read word is zero, so `rd_data` reads zero with `rd_async` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write port clock |
| wr_en | input | 1 | Write enable, sampled on rising wr_clk |
| wr_addr | input | 9 | Write word address |
| wr_data | input | 18 | Write data, low bits used in narrow shapes |
| rd_clk | input | 1 | Read port clock |
| rst_n | input | 1 | Active-low asynchronous clear of the registered read word |
| rd_en | input | 1 | Read enable for registered reads |
| rd_addr | input | 9 | Read word address |
| rd_async | input | 1 | 1 = flow-through read, 0 = registered read |
| shape | input | 2 | Depth-by-width organisation select |
| rd_data | output | 18 | Read data, upper bits zero in narrow shapes |

## Verification
The bench first fills the whole pool under the widest shape. It then changes shapes so that reads must pick out bit offsets that straddle old word boundaries. A design that computed the pool offset from the wrong width would return slices of neighbouring words. Aliased high addresses and all-ones write data are driven to catch designs that decode too many address bits or leak upper data bits into the pool or onto the output. Same-word write-then-read is exercised in both read modes with unrelated clock periods, along with reads while the enable is low. A late forwarding path, or a register that loads regardless of the enable, shows up as a stale or a moved value.

// File: rtl/cfg_aspect_dpram_pkg.sv
`timescale 1ns/1ps
package cfg_aspect_dpram_pkg;
    localparam int SHAPE_W = 2;

    // Organisation codes; the index n gives width DATA_W>>n and depth BASE<<n
    typedef enum logic [SHAPE_W-1:0] {
        SHP_W18 = 2'b00,
        SHP_W9  = 2'b01,
        SHP_W4  = 2'b10,
        SHP_W2  = 2'b11
    } shape_e;
endpackage

// File: rtl/ram_shape_decode.sv
`timescale 1ns/1ps
module ram_shape_decode
    import cfg_aspect_dpram_pkg::*;
#(
    parameter int DATA_W     = 18,
    parameter int ADDR_W     = 9,
    parameter int TOTAL_BITS = 1152,
    parameter int IDX_W      = $clog2(TOTAL_BITS),
    parameter int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic [SHAPE_W-1:0] shape,
    input  logic [ADDR_W-1:0]  addr,
    output logic [IDX_W-1:0]   base,
    output logic [CNT_W-1:0]   width,
    output logic [DATA_W-1:0]  mask
);
    localparam int BASE_DEPTH = TOTAL_BITS / DATA_W;
    localparam logic [ADDR_W-1:0] DM0 = ADDR_W'((BASE_DEPTH << 0) - 1);
    localparam logic [ADDR_W-1:0] DM1 = ADDR_W'((BASE_DEPTH << 1) - 1);
    localparam logic [ADDR_W-1:0] DM2 = ADDR_W'((BASE_DEPTH << 2) - 1);
    localparam logic [ADDR_W-1:0] DM3 = ADDR_W'((BASE_DEPTH << 3) - 1);

    logic [ADDR_W-1:0] depth_m;
    logic [ADDR_W-1:0] addr_eff;

    always_comb begin
        unique case (shape_e'(shape))
            SHP_W18: begin width = CNT_W'(DATA_W >> 0); depth_m = DM0; end
            SHP_W9:  begin width = CNT_W'(DATA_W >> 1); depth_m = DM1; end
            SHP_W4:  begin width = CNT_W'(DATA_W >> 2); depth_m = DM2; end
            SHP_W2:  begin width = CNT_W'(DATA_W >> 3); depth_m = DM3; end
            default: begin width = CNT_W'(DATA_W);      depth_m = DM0; end
        endcase
    end

    always_comb begin
        addr_eff = addr & depth_m;
        base     = IDX_W'(addr_eff) * IDX_W'(width);
        for (int i = 0; i < DATA_W; i++) begin
            mask[i] = (CNT_W'(i) < width);
        end
    end
endmodule

// File: rtl/ram_bit_array.sv
`timescale 1ns/1ps
module ram_bit_array #(
    parameter int DATA_W     = 18,
    parameter int TOTAL_BITS = 1152,
    parameter int IDX_W      = $clog2(TOTAL_BITS),
    parameter int CNT_W      = $clog2(DATA_W + 1)
) (
    input  logic              wr_clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_base,
    input  logic [CNT_W-1:0]  wr_width,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_base,
    input  logic [CNT_W-1:0]  rd_width,
    output logic [DATA_W-1:0] rd_word
);
    logic [TOTAL_BITS-1:0] pool_q;
    logic [DATA_W-1:0]     wsel;
    logic [IDX_W-1:0]      widx [DATA_W];
    logic [IDX_W-1:0]      ridx [DATA_W];

    // Per-lane pool index for the write and read words
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            wsel[i] = wr_en && (CNT_W'(i) < wr_width);
            widx[i] = (CNT_W'(i) < wr_width) ? wr_base + IDX_W'(i) : '0;
            ridx[i] = (CNT_W'(i) < rd_width) ? rd_base + IDX_W'(i) : '0;
        end
    end

    always_ff @(posedge wr_clk) begin
        for (int i = 0; i < DATA_W; i++) begin
            if (wsel[i]) begin
                pool_q[widx[i]] <= wr_data[i];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            rd_word[i] = (CNT_W'(i) < rd_width) ? pool_q[ridx[i]] : 1'b0;
        end
    end
endmodule

// File: rtl/ram_read_port.sv
`timescale 1ns/1ps
module ram_read_port #(
    parameter int DATA_W = 18
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              rd_async,
    input  logic [DATA_W-1:0] comb_word,
    input  logic [DATA_W-1:0] mask,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word_q;

    // Registered read word
    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (rd_en) begin
            word_q <= comb_word;
        end
    end

    // Output select and width masking
    always_comb begin
        rd_data = (rd_async ? comb_word : word_q) & mask;
    end
endmodule

// File: rtl/cfg_aspect_dpram.sv
`timescale 1ns/1ps
module cfg_aspect_dpram
    import cfg_aspect_dpram_pkg::*;
#(
    parameter int DATA_W     = 18,
    parameter int ADDR_W     = 9,
    parameter int TOTAL_BITS = 1152
) (
    input  logic               wr_clk,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               rd_clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  rd_addr,
    input  logic               rd_async,
    input  logic [SHAPE_W-1:0] shape,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int IDX_W = $clog2(TOTAL_BITS);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [IDX_W-1:0]  wbase, rbase;
    logic [CNT_W-1:0]  wwidth, rwidth;
    logic [DATA_W-1:0] wmask, rmask;
    logic [DATA_W-1:0] rword;

    ram_shape_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOTAL_BITS(TOTAL_BITS),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_wdec (
        .shape(shape), .addr(wr_addr), .base(wbase), .width(wwidth), .mask(wmask)
    );

    ram_shape_decode #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOTAL_BITS(TOTAL_BITS),
        .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_rdec (
        .shape(shape), .addr(rd_addr), .base(rbase), .width(rwidth), .mask(rmask)
    );

    ram_bit_array #(
        .DATA_W(DATA_W), .TOTAL_BITS(TOTAL_BITS), .IDX_W(IDX_W), .CNT_W(CNT_W)
    ) u_pool (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_base(wbase), .wr_width(wwidth),
        .wr_data(wr_data & wmask), .rd_base(rbase), .rd_width(rwidth),
        .rd_word(rword)
    );

    ram_read_port #(.DATA_W(DATA_W)) u_rport (
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_async(rd_async),
        .comb_word(rword), .mask(rmask), .rd_data(rd_data)
    );
endmodule

// File: rtl/cfg_aspect_dpram_chk.sv
`timescale 1ns/1ps
module cfg_aspect_dpram_chk #(
    parameter int DATA_W     = 18,
    parameter int ADDR_W     = 9,
    parameter int TOTAL_BITS = 1152
) (
    input logic              wr_clk,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_async,
    input logic [1:0]        shape,
    input logic [DATA_W-1:0] rd_data
);
    localparam int BASE_DEPTH = TOTAL_BITS / DATA_W;

    logic [DATA_W-1:0] lane_mask;
    logic [ADDR_W-1:0] amask;
    logic              same_word;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            lane_mask[i] = (i < (DATA_W >> shape));
        end
        amask     = ADDR_W'((BASE_DEPTH << shape) - 1);
        same_word = ((wr_addr & amask) == (rd_addr & amask));
    end

    assert_upper_zero_R4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (rd_data & ~lane_mask) == '0);

    assert_hold_R6: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!rd_async && !rd_en) |=> (rd_async || !$stable(shape) || $stable(rd_data)));

    assert_async_visible_R8: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && rd_async && same_word) |=>
        (!rd_async || !$stable(rd_addr) || !$stable(shape) ||
         rd_data == ($past(wr_data) & lane_mask)));

    assert_reset_clear_R9: assert property (@(posedge rd_clk)
        (!rst_n && !rd_async) |-> rd_data == '0);
endmodule

bind cfg_aspect_dpram cfg_aspect_dpram_chk #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .TOTAL_BITS(TOTAL_BITS)
) u_chk (
    .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_async(rd_async), .shape(shape), .rd_data(rd_data)
);

// File: tb/cfg_aspect_dpram_tb.sv
`timescale 1ns/1ps
module cfg_aspect_dpram_tb;
    localparam int DW = 18;
    localparam int AW = 9;
    localparam int NB = 1152;

    logic          wr_clk = 0, rd_clk = 0;
    logic          wr_en = 0, rd_en = 0, rd_async = 0;
    logic          rst_n = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    shape = 2'b00;
    logic [DW-1:0] rd_data;

    bit [NB-1:0] refm;
    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 wr_clk = ~wr_clk;   // 200 MHz
    always #3.7 rd_clk = ~rd_clk;   // unrelated read clock

    cfg_aspect_dpram u_dut (
        .wr_clk(wr_clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_async(rd_async), .shape(shape), .rd_data(rd_data)
    );

    function automatic int wid(input logic [1:0] m);
        return DW >> m;
    endfunction

    function automatic int eff(input logic [1:0] m, input logic [AW-1:0] a);
        return int'(a) % (64 << m);
    endfunction

    function automatic logic [DW-1:0] ref_read(input logic [1:0] m, input logic [AW-1:0] a);
        logic [DW-1:0] r = '0;
        for (int i = 0; i < wid(m); i++) r[i] = refm[eff(m, a) * wid(m) + i];
        return r;
    endfunction

    task automatic ref_write(input logic [1:0] m, input logic [AW-1:0] a, input logic [DW-1:0] d);
        for (int i = 0; i < wid(m); i++) refm[eff(m, a) * wid(m) + i] = d[i];
    endtask

    task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: rd_data=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_addr = a; wr_data = d; wr_en = 1;
        @(negedge wr_clk);
        wr_en = 0;
        ref_write(shape, a, d);
    endtask

    task automatic sync_read(input string tag, input logic [AW-1:0] a);
        @(negedge rd_clk);
        rd_async = 0; rd_addr = a; rd_en = 1;
        @(negedge rd_clk);
        rd_en = 0;
        check(tag, rd_data, ref_read(shape, a));
    endtask

    task automatic async_read(input string tag, input logic [AW-1:0] a);
        rd_async = 1; rd_addr = a;
        #1;
        check(tag, rd_data, ref_read(shape, a));
    endtask

    initial begin
        logic [DW-1:0] held;
        void'($urandom(32'h5EED_0042));
        // R9: reset clears registered word
        #1;
        check("R9 reset", rd_data, '0);
        repeat (3) @(negedge rd_clk);
        rst_n = 1;

        // Fill whole pool in widest shape
        shape = 2'b00;
        for (int a = 0; a < 64; a++) do_write(AW'(a), DW'($urandom));

        // R1: cross-shape reinterpretation by bit offset
        do_write(9'd1, 18'h2A5C3);
        shape = 2'b11;
        sync_read("R1 cross 512x2", 9'd9);
        shape = 2'b01;
        async_read("R1 cross 128x9", 9'd2);
        shape = 2'b10;
        async_read("R1 cross 256x4", 9'd5);

        // Random traffic per shape
        for (int m = 0; m < 4; m++) begin
            shape = 2'(m);
            rd_async = 0;
            repeat (2) @(negedge rd_clk);
            for (int k = 0; k < 150; k++) begin
                case ($urandom % 4)
                    0, 1: do_write(AW'($urandom), DW'($urandom));
                    2: sync_read("R5 sync read", AW'($urandom));
                    default: async_read("R7 async read", AW'($urandom));
                endcase
            end
        end

        // R3: aliased address under 128x9
        shape = 2'b01;
        do_write(9'h185, 18'h1A5);
        sync_read("R3 alias", 9'h005);
        check("R3 alias value", rd_data, 18'h1A5);

        // R4: all-ones data under 512x2
        shape = 2'b11;
        do_write(9'h1F0, 18'h3FFFF);
        async_read("R4 upper zero", 9'h1F0);
        check("R4 upper zero value", rd_data, 18'h00003);

        // R2: enable low leaves pool unchanged
        shape = 2'b00;
        do_write(9'd7, 18'h12345);
        @(negedge wr_clk);
        wr_addr = 9'd7; wr_data = 18'h0BEEF; wr_en = 0;
        repeat (3) @(negedge wr_clk);
        sync_read("R2 no write", 9'd7);
        check("R2 no write value", rd_data, 18'h12345);

        // R6: hold with enable low, new address and a rewrite
        do_write(9'd8, 18'h00FF0);
        sync_read("R6 setup", 9'd7);
        held = rd_data;
        @(negedge rd_clk);
        rd_addr = 9'd8; rd_en = 0;
        do_write(9'd7, 18'h3C3C3);
        repeat (3) @(negedge rd_clk);
        check("R6 hold", rd_data, held);

        // R8: registered mode, same word
        @(negedge rd_clk);
        rd_async = 0; rd_addr = 9'd20; rd_en = 1;
        @(negedge rd_clk);
        check("R8 sync before", rd_data, ref_read(shape, 9'd20));
        do_write(9'd20, 18'h2D2D2);
        repeat (2) @(negedge rd_clk);
        check("R8 sync after", rd_data, 18'h2D2D2);
        rd_en = 0;

        // R8: flow-through mode, visible right after write edge
        shape = 2'b01;
        rd_async = 1; rd_addr = 9'd33;
        @(negedge wr_clk);
        wr_addr = 9'd33; wr_data = 18'h3FE5A; wr_en = 1;
        @(posedge wr_clk);
        #0.5;
        check("R8 async after edge", rd_data, 18'h0005A);
        @(negedge wr_clk);
        wr_en = 0;
        ref_write(shape, 9'd33, 18'h3FE5A);

        // R9: reset mid-run clears registered word
        sync_read("R9 pre", 9'd33);
        rst_n = 0;
        #1;
        check("R9 mid-run clear", rd_data, '0);
        @(negedge rd_clk);
        rst_n = 1;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: rd_data=%h expected=completion", rd_data);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule